// File: doc/BRIEF.md
# Window Limit Watchdog Scanner

This block watches a set of digital sample channels (two by default, eight in the wide build). Each channel is checked against a lower and an upper limit held in a small limit store. The scanner visits the channels in turn. For each channel it runs a lower-side check and then an upper-side check, and it loops over all channels for as long as scanning is enabled. When a check fails, the block records which channel and which side failed. It sets a pending flag and pulls its active-low alarm outputs low.

The host controls the block with a single select line, `csel`. A falling edge on `csel` releases the alarm. One cycle later the block presents the recorded status and tag for a single cycle, and then clears them. The same falling edge can also latch a new mode word. This happens only when `csel` was high for a short time before it fell, so the host can change the mode between reads with a short pulse. The limits are written through a simple synchronous port, and only while the scanner is idle.

The block is built around two state machines. The scan machine has three states:
- SC_IDLE: waits for the run bit.
- SC_LOWER: runs the lower-side check.
- SC_UPPER: runs the upper-side check.

Its transitions are:
- SC_IDLE to SC_LOWER when run is set.
- SC_LOWER to SC_UPPER at the end of a comparison slot.
- SC_UPPER to SC_LOWER at the end of a slot, with the channel pointer stepping up and wrapping to zero.
- Any scanning state to SC_IDLE when run is cleared.

The handshake machine has four states:
- HS_QUIET: no alarm.
- HS_ALARM: alarm held.
- HS_RELEASE: alarm just released.
- HS_SEND: data presented.

Its transitions are:
- HS_QUIET to HS_ALARM on a failed check, or when a flag is already pending.
- HS_ALARM to HS_RELEASE on a `csel` falling edge.
- HS_RELEASE to HS_SEND after one cycle.
- HS_SEND to HS_QUIET after one cycle.

Top module: `wd_window_scanner`

## Requirements
- R1: A synchronous active-high `rst` clears the status, the tag, the channel pointer and the mode. After reset, `int_n`, `comp_lo_n` and `comp_hi_n` are high, `rd_valid` is low, and no scanning takes place until a mode with bit 0 set has been latched.
- R2: The lower-side check of a channel fails when its sample is not strictly greater than its lower limit. A sample equal to the lower limit therefore fails.
- R3: The upper-side check of a channel fails when its sample is not strictly less than its upper limit. A sample equal to the upper limit therefore fails.
- R4: Channels are scanned in ascending order, with the lower check before the upper check. The tag of a failure is 2*channel + side, where side is 0 for lower and 1 for upper. The tag keeps the first failure since the last read.
- R5: `rd_status` is NUM_CH+1 bits wide. The MSB is set by any failure. Bit c is set when channel c has failed either check, so later failures are also recorded.
- R6: When a lower limit is set above its upper limit, a sample lying between the two limits fails both checks. Bit c of the status is set, and both comparison outputs go low.
- R7: `int_n` goes low after a failed check and stays low for as long as `csel` stays high.
- R8: In the two-channel build, `comp_lo_n` goes low for a lower-side failure and `comp_hi_n` goes low for an upper-side failure. Both go low when both sides have failed. In other builds both are tied high.
- R9: On the clock edge that first samples `csel` low while the alarm is held, `int_n`, `comp_lo_n` and `comp_hi_n` return high. On the next cycle `rd_valid` is high for exactly one cycle, carrying the status and tag captured at the release. The internal status and tag are cleared at that release edge.
- R10: `mode_in` is latched on a `csel` falling edge only when `csel` was sampled high on fewer than HOLD edges before it fell. HOLD is 8 in the two-channel build and 32 otherwise. Bit 0 of the mode enables scanning.
- R11: The limit address uses the same encoding as the tag. A write is accepted only while the scanner is in SC_IDLE, and writes during scanning are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samples_in | input | NUM_CH*DW | Packed channel samples, channel c at bits [c*DW +: DW] |
| lim_we | input | 1 | Limit write enable |
| lim_addr | input | TW | Limit address, 2*channel + side |
| lim_data | input | DW | Limit value to write |
| csel | input | 1 | Host select line; a falling edge releases the alarm and may latch the mode |
| mode_in | input | MW | Mode word; bit 0 enables scanning |
| int_n | output | 1 | Active-low alarm |
| comp_lo_n | output | 1 | Active-low lower-side failure indicator |
| comp_hi_n | output | 1 | Active-low upper-side failure indicator |
| rd_valid | output | 1 | One-cycle strobe for the read-out data |
| rd_status | output | NUM_CH+1 | Captured status: MSB is the pending flag, bit c is channel c failed |
| rd_tag | output | TW | Captured tag of the first failure |

## Verification
The scanner is exercised with these sample and limit patterns:
- All samples inside their windows, to show that quiet inputs raise nothing.
- A lone lower-side failure and a lone upper-side failure, to tell apart the two comparison outputs and the tag side bit.
- Samples sitting exactly on each limit, to separate strict from non-strict comparison.
- An inverted window, to confirm that both sides fail together.
- Failures on both channels with the upper side of channel 0 failing, to show that the tag keeps the earliest failure in scan order while the status collects every channel.

Each read is scored against a queue of expected status and tag values built from the limits and samples. Further checks cover the release edge and the one-cycle delay before data appears. A limit write made during scanning and a `csel` high period longer than HOLD are both shown to leave the outputs as if they had never happened.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_LOWER,
        SC_UPPER
    } scan_st_e;

    typedef enum logic [1:0] {
        HS_QUIET,
        HS_ALARM,
        HS_RELEASE,
        HS_SEND
    } hs_st_e;

endpackage

// File: rtl/wd_limit_ram.sv
module wd_limit_ram #(
    parameter int NUM_CH = 2,
    parameter int DW     = 8,
    parameter int AW     = 2
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 2 * NUM_CH;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wd_side_check.sv
module wd_side_check #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] limit,
    input  logic          upper_side,
    output logic          crossed
);
    // Lower side passes only when the sample is strictly above the limit;
    // the upper side passes only when it is strictly below.
    always_comb begin
        if (upper_side) begin
            crossed = !(sample < limit);
        end else begin
            crossed = !(sample > limit);
        end
    end

endmodule

// File: rtl/wd_cfg_latch.sv
module wd_cfg_latch #(
    parameter int HOLD = 8,
    parameter int MW   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csel,
    input  logic [MW-1:0] mode_in,
    output logic [MW-1:0] mode_q,
    output logic          sel_fall
);
    localparam int CNTW = $clog2(HOLD + 1);

    logic            csel_q;
    logic [CNTW-1:0] hi_cnt;

    assign sel_fall = csel_q && !csel;

    always_ff @(posedge clk) begin
        if (rst) begin
            csel_q <= 1'b0;
            hi_cnt <= '0;
            mode_q <= '0;
        end else begin
            csel_q <= csel;
            if (csel) begin
                if (hi_cnt != CNTW'(HOLD)) begin
                    hi_cnt <= hi_cnt + CNTW'(1);
                end
            end else begin
                hi_cnt <= '0;
            end
            if (sel_fall && (hi_cnt < CNTW'(HOLD))) begin
                mode_q <= mode_in;
            end
        end
    end

endmodule

// File: rtl/wd_window_scanner.sv
module wd_window_scanner
    import wd_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int DW      = 8,
    parameter int CMP_CYC = 1,
    parameter int MW      = 1,
    parameter int TW      = $clog2(2 * NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH*DW-1:0] samples_in,
    input  logic                 lim_we,
    input  logic [TW-1:0]        lim_addr,
    input  logic [DW-1:0]        lim_data,
    input  logic                 csel,
    input  logic [MW-1:0]        mode_in,
    output logic                 int_n,
    output logic                 comp_lo_n,
    output logic                 comp_hi_n,
    output logic                 rd_valid,
    output logic [NUM_CH:0]      rd_status,
    output logic [TW-1:0]        rd_tag
);
    localparam int CW   = $clog2(NUM_CH);
    localparam int SW   = (CMP_CYC > 1) ? $clog2(CMP_CYC) : 1;
    localparam int HOLD = (NUM_CH == 2) ? 8 : 32;

    scan_st_e sc_st, sc_nx;
    hs_st_e   hs_st, hs_nx;

    logic [CW-1:0]   ch;
    logic [SW-1:0]   slot;
    logic            slot_last;
    logic [MW-1:0]   mode_q;
    logic            run;
    logic            sel_fall;
    logic [TW-1:0]   lim_rd_addr;
    logic [DW-1:0]   lim_val;
    logic [DW-1:0]   cur_sample;
    logic            upper_sel;
    logic            side_crossed;
    logic            hit, hit_lo, hit_hi;
    logic            take;
    logic            first;
    logic [NUM_CH:0] status;
    logic [TW-1:0]   tag;
    logic            pend_lo, pend_hi;
    logic [NUM_CH:0] snap_status;
    logic [TW-1:0]   snap_tag;

    // ---------------- configuration latch ----------------
    wd_cfg_latch #(
        .HOLD (HOLD),
        .MW   (MW)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .csel     (csel),
        .mode_in  (mode_in),
        .mode_q   (mode_q),
        .sel_fall (sel_fall)
    );

    assign run = mode_q[0];

    // ---------------- limit store and comparator ----------------
    assign upper_sel   = (sc_st == SC_UPPER);
    assign lim_rd_addr = TW'({ch, upper_sel});
    assign cur_sample  = samples_in[int'(ch)*DW +: DW];

    wd_limit_ram #(
        .NUM_CH (NUM_CH),
        .DW     (DW),
        .AW     (TW)
    ) u_lim (
        .clk     (clk),
        .wr_en   (lim_we && (sc_st == SC_IDLE)),
        .wr_addr (lim_addr),
        .wr_data (lim_data),
        .rd_addr (lim_rd_addr),
        .rd_data (lim_val)
    );

    wd_side_check #(
        .DW (DW)
    ) u_cmp (
        .sample     (cur_sample),
        .limit      (lim_val),
        .upper_side (upper_sel),
        .crossed    (side_crossed)
    );

    assign slot_last = (slot == SW'(CMP_CYC - 1));
    assign hit    = run && (sc_st != SC_IDLE) && slot_last && side_crossed;
    assign hit_lo = hit && (sc_st == SC_LOWER);
    assign hit_hi = hit && (sc_st == SC_UPPER);

    // ---------------- scan state machine ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            sc_st <= SC_IDLE;
        end else begin
            sc_st <= sc_nx;
        end
    end

    always_comb begin
        sc_nx = sc_st;
        unique case (sc_st)
            SC_IDLE:  if (run) sc_nx = SC_LOWER;
            SC_LOWER: begin
                if (!run)          sc_nx = SC_IDLE;
                else if (slot_last) sc_nx = SC_UPPER;
            end
            SC_UPPER: begin
                if (!run)          sc_nx = SC_IDLE;
                else if (slot_last) sc_nx = SC_LOWER;
            end
            default:  sc_nx = SC_IDLE;
        endcase
    end

    // channel pointer and comparison slot counter
    always_ff @(posedge clk) begin
        if (rst || (sc_st == SC_IDLE) || !run) begin
            ch   <= '0;
            slot <= '0;
        end else if (slot_last) begin
            slot <= '0;
            if (sc_st == SC_UPPER) begin
                ch <= (ch == CW'(NUM_CH - 1)) ? '0 : ch + CW'(1);
            end
        end else begin
            slot <= slot + SW'(1);
        end
    end

    // ---------------- handshake state machine ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_st <= HS_QUIET;
        end else begin
            hs_st <= hs_nx;
        end
    end

    always_comb begin
        hs_nx = hs_st;
        unique case (hs_st)
            HS_QUIET:   if (hit || status[NUM_CH]) hs_nx = HS_ALARM;
            HS_ALARM:   if (sel_fall) hs_nx = HS_RELEASE;
            HS_RELEASE: hs_nx = HS_SEND;
            HS_SEND:    hs_nx = HS_QUIET;
            default:    hs_nx = HS_QUIET;
        endcase
    end

    // ---------------- status, tag and capture ----------------
    assign take  = (hs_st == HS_ALARM) && sel_fall;
    assign first = !status[NUM_CH] || take;

    always_ff @(posedge clk) begin
        if (rst) begin
            status      <= '0;
            tag         <= '0;
            pend_lo     <= 1'b0;
            pend_hi     <= 1'b0;
            snap_status <= '0;
            snap_tag    <= '0;
        end else begin
            if (take) begin
                snap_status <= status;
                snap_tag    <= tag;
                status      <= '0;
                tag         <= '0;
                pend_lo     <= 1'b0;
                pend_hi     <= 1'b0;
            end
            if (hit) begin
                status[NUM_CH] <= 1'b1;
                status[ch]     <= 1'b1;
                if (first) begin
                    tag <= TW'({ch, upper_sel});
                end
                if (hit_lo) pend_lo <= 1'b1;
                if (hit_hi) pend_hi <= 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        int_n     = (hs_st != HS_ALARM);
        rd_valid  = (hs_st == HS_SEND);
        rd_status = snap_status;
        rd_tag    = snap_tag;
    end

    generate
        if (NUM_CH == 2) begin : g_side_pins
            assign comp_lo_n = !((hs_st == HS_ALARM) && pend_lo);
            assign comp_hi_n = !((hs_st == HS_ALARM) && pend_hi);
        end else begin : g_no_side_pins
            assign comp_lo_n = 1'b1;
            assign comp_hi_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/wd_scanner_chk.sv
module wd_scanner_chk #(
    parameter int NUM_CH = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            csel,
    input logic            int_n,
    input logic            comp_lo_n,
    input logic            comp_hi_n,
    input logic            rd_valid,
    input logic [NUM_CH:0] rd_status
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (int_n && comp_lo_n && comp_hi_n && !rd_valid)); // R1

    AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!int_n && csel) |=> !int_n); // R7

    AST_SIDE_WITH_INT: assert property (@(posedge clk) disable iff (rst)
        (!comp_lo_n || !comp_hi_n) |-> !int_n); // R8

    AST_READ_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(int_n) |=> rd_valid); // R9

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R9

    AST_PENDING_FLAG: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_status[NUM_CH]); // R5

endmodule

bind wd_window_scanner wd_scanner_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .csel      (csel),
    .int_n     (int_n),
    .comp_lo_n (comp_lo_n),
    .comp_hi_n (comp_hi_n),
    .rd_valid  (rd_valid),
    .rd_status (rd_status)
);

// File: tb/wd_window_scanner_tb.sv
module wd_window_scanner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int DW  = 8;
    localparam int TW  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH*DW-1:0] samples_in = '0;
    logic              lim_we = 1'b0;
    logic [TW-1:0]     lim_addr = '0;
    logic [DW-1:0]     lim_data = '0;
    logic              csel = 1'b0;
    logic [0:0]        mode_in = '0;
    logic              int_n, comp_lo_n, comp_hi_n, rd_valid;
    logic [NCH:0]      rd_status;
    logic [TW-1:0]     rd_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    wd_window_scanner u_dut (
        .clk        (clk),
        .rst        (rst),
        .samples_in (samples_in),
        .lim_we     (lim_we),
        .lim_addr   (lim_addr),
        .lim_data   (lim_data),
        .csel       (csel),
        .mode_in    (mode_in),
        .int_n      (int_n),
        .comp_lo_n  (comp_lo_n),
        .comp_hi_n  (comp_hi_n),
        .rd_valid   (rd_valid),
        .rd_status  (rd_status),
        .rd_tag     (rd_tag)
    );

    typedef struct packed {
        logic [NCH:0]  st;
        logic [TW-1:0] tg;
    } rd_item_t;

    rd_item_t exp_q[$];
    rd_item_t got_item;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int lo_l[NCH];
    int hi_l[NCH];
    int smp[NCH];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected rd_valid", 1, 0);
            end else begin
                got_item = exp_q.pop_front();
                chk("R5 rd_status", int'(rd_status), int'(got_item.st));
                chk("R4 rd_tag", int'(rd_tag), int'(got_item.tg));
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; csel = 1'b0; lim_we = 1'b0; mode_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_lim(input int a, input int d);
        lim_we = 1'b1; lim_addr = a[TW-1:0]; lim_data = d[DW-1:0];
        @(negedge clk);
        lim_we = 1'b0;
    endtask

    task automatic load_all();
        for (int c = 0; c < NCH; c++) begin
            write_lim(2*c, lo_l[c]);     // R11 address = 2*ch + side
            write_lim(2*c + 1, hi_l[c]);
            samples_in[c*DW +: DW] = smp[c][DW-1:0];
        end
    endtask

    task automatic short_pulse();
        mode_in = 1'b1; csel = 1'b1;
        repeat (3) @(negedge clk);
        csel = 1'b0;
        @(negedge clk);
        csel = 1'b1;
    endtask

    task automatic set_ch(input int c, input int lo, input int hi, input int s);
        lo_l[c] = lo; hi_l[c] = hi; smp[c] = s;
    endtask

    // wait, check the alarm pins, then read out and score
    task automatic check_case(input string name, input bit mid_write);
        rd_item_t e;
        bit any_f = 0, any_lo = 0, any_hi = 0, tag_set = 0;
        e = '0;
        for (int c = 0; c < NCH; c++) begin
            bit lof, hif;
            lof = !(smp[c] > lo_l[c]);   // R2
            hif = !(smp[c] < hi_l[c]);   // R3
            if (lof || hif) begin
                any_f = 1; e.st[c] = 1'b1; e.st[NCH] = 1'b1;
            end
            if (lof) any_lo = 1;
            if (hif) any_hi = 1;
            if (!tag_set && lof) begin e.tg = TW'(2*c);     tag_set = 1; end
            if (!tag_set && hif) begin e.tg = TW'(2*c + 1); tag_set = 1; end
        end
        if (mid_write) begin
            repeat (10) @(negedge clk);
            write_lim(2, 0);             // R11 ignored while scanning
            repeat (20) @(negedge clk);
        end else begin
            repeat (30) @(negedge clk);
        end
        $display("case %s", name);
        chk("R7 int_n held", int'(int_n), any_f ? 0 : 1);
        chk("R8 comp_lo_n", int'(comp_lo_n), any_lo ? 0 : 1);
        chk("R8 comp_hi_n", int'(comp_hi_n), any_hi ? 0 : 1);
        if (any_f) begin
            exp_q.push_back(e);
            csel = 1'b0;
            @(negedge clk);
            chk("R9 int_n released", int'(int_n), 1);
            chk("R9 comp_lo_n released", int'(comp_lo_n), 1);
            chk("R9 comp_hi_n released", int'(comp_hi_n), 1);
            chk("R9 rd_valid not yet", int'(rd_valid), 0);
            repeat (3) @(negedge clk);
            chk("R9 read delivered", exp_q.size(), 0);
        end
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 int_n", int'(int_n), 1);
        chk("R1 comp_lo_n", int'(comp_lo_n), 1);
        chk("R1 comp_hi_n", int'(comp_hi_n), 1);
        chk("R1 rd_valid", int'(rd_valid), 0);

        // R10 / R1: long csel high does not latch the mode, so no scan
        set_ch(0, 50, 200, 10); set_ch(1, 50, 200, 100);
        load_all();
        mode_in = 1'b1; csel = 1'b1;
        repeat (40) @(negedge clk);
        csel = 1'b0;
        repeat (2) @(negedge clk);
        csel = 1'b1;
        repeat (30) @(negedge clk);
        chk("R10 long pulse ignored int_n", int'(int_n), 1);
        chk("R1 no scan before mode", int'(comp_lo_n), 1);
        csel = 1'b0;
        repeat (2) @(negedge clk);
        short_pulse();                   // R10 short pulse latches run
        check_case("R10 short pulse", 0);

        // R2/R3 all inside windows
        do_reset();
        set_ch(0, 50, 200, 100); set_ch(1, 50, 200, 120);
        load_all(); short_pulse(); check_case("quiet", 0);

        // R2 lone lower failure
        do_reset();
        set_ch(0, 50, 200, 30); set_ch(1, 50, 200, 120);
        load_all(); short_pulse(); check_case("R2 lower", 0);

        // R3 lone upper failure on channel 1
        do_reset();
        set_ch(0, 50, 200, 100); set_ch(1, 50, 200, 250);
        load_all(); short_pulse(); check_case("R3 upper", 0);

        // R2/R3 samples exactly on the limits
        do_reset();
        set_ch(0, 50, 200, 50); set_ch(1, 50, 200, 200);
        load_all(); short_pulse(); check_case("R2 R3 equal", 0);

        // R6 inverted window, sample inside
        do_reset();
        set_ch(0, 50, 200, 100); set_ch(1, 150, 100, 120);
        load_all(); short_pulse(); check_case("R6 inverted", 0);

        // R11 write while scanning is ignored
        do_reset();
        set_ch(0, 50, 200, 100); set_ch(1, 150, 220, 120);
        load_all(); short_pulse(); check_case("R11 busy write", 1);

        // R4/R5 both channels fail, channel 0 on its upper side
        do_reset();
        set_ch(0, 50, 90, 100); set_ch(1, 150, 220, 120);
        load_all(); short_pulse(); check_case("R4 R5 multi", 0);

        done = 1;
        report();
        $finish;
    end

endmodule